// File: doc/BRIEF.md
# Gigabit PCS Management Register File

This block is the 16-bit control and status register file that sits beside a gigabit Ethernet PCS able to run as 1000BASE-X or as SGMII. Software reaches it through a simple word-addressed port with separate read and write strobes. The registers cover soft reset, auto-negotiation control, status, the advertised and partner ability words, the expansion flags, a scratch word, a 21-bit link timer and the interface mode. The block drives its control fields to the PCS core and takes status and partner-ability values back from it.

Every field keeps its own access rule. Some are plain read-write. Some are read-only and mirror the core. Two are request bits that software sets by writing 1 and the block clears when the core acknowledges. The new-page flag clears when it is read. The link bit latches low. The link timer has low bits that are hard-wired to zero. The block also gives the core an effective speed code, worked out from the interface-mode fields.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: After reset the registers read as follows: control (word 0x00) 0x0000, status link bit 0, advertised ability (0x04) 0x01A0, expansion page flag 0, scratch (0x10) 0x0000, timer low (0x12) 0x8A00, timer high (0x13) 0x0009, interface mode (0x14) 0x0000. All control outputs match these values.
- R2: Read data is registered. It appears one cycle after the cycle in which rd_en is high and holds until the next read. A read and a write to the same word in the same cycle return the value from before the write.
- R3: Control bit 15 (soft reset) is set by a write with wdata[15]=1. A write with 0 leaves it as it is. It stays set until a cycle with rst_done high, and it reads 0 in the cycle after that. If a set and rst_done arrive in the same cycle, the set wins. No other register changes while the request is pending.
- R4: Control bit 9 (negotiation restart) behaves like bit 15 but is cleared by an_restart_ack. Control bit 12 is plain read-write and drives an_enable.
- R5: Status (0x01) bit 3 always reads 1. Bit 5 is the live an_complete input. Bit 2 latches low: a cycle with link_up low forces it to 0. It stays 0 until a status read, and that read loads the current link_up value.
- R6: Expansion (0x06) bit 1 sets on page_rx and clears after a read of 0x06. If page_rx and the read coincide, the flag stays set. Bit 0 is the live partner_an_able input.
- R7: The link timer is 21 bits. Word 0x12 holds timer bits 15:0 and word 0x13 bits 4:0 hold timer bits 20:16. Timer bits 8:0 read as 0 and ignore writes. The reset value is 0x98A00.
- R8: In the advertised-ability word only bits 13:12, 8:7 and 5 are writable (mask 0x31A0). The word drives adv_ability.
- R9: Interface mode (0x14) bit 0 selects SGMII (1) or 1000BASE-X (0), bit 1 takes the speed from negotiation, and bits 3:2 give a manual speed (00 10M, 01 100M, 10 1G). The speed_sel output is 10 when bit 0 is 0, partner_ability[11:10] when bits 1:0 are 11, and bits 3:2 otherwise.
- R10: Word 0x05 reads the partner_ability input. Words 0x07 and 0x08 read 0. Scratch (0x10) is a 16-bit read-write word.
- R11: Reserved bits and unmapped words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rst_done | input | 1 | Core reports that the soft reset is complete |
| an_restart_ack | input | 1 | Core reports that the negotiation restart has begun |
| link_up | input | 1 | Live link state from the core |
| an_complete | input | 1 | Negotiation complete from the core |
| page_rx | input | 1 | Pulse when a new partner page arrives |
| partner_an_able | input | 1 | Partner supports negotiation |
| partner_ability | input | 16 | Partner ability word from the core |
| soft_rst_req | output | 1 | Pending soft reset request |
| an_restart_req | output | 1 | Pending negotiation restart request |
| an_enable | output | 1 | Negotiation enable |
| adv_ability | output | 16 | Advertised ability word |
| link_timer | output | 21 | Link timer value |
| sgmii_en | output | 1 | SGMII mode select |
| use_an_speed | output | 1 | Take speed from negotiation |
| speed_sel | output | 2 | Effective speed code |

## Verification
Read data is due in the cycle after the read strobe. Register outputs, request bits, latched flags and speed_sel are due in the cycle after the write or core event that changes them. The bench drives inputs on the falling edge and keeps a model that steps once per rising edge. It takes the expected read value from the model state before that edge, and it compares both read data and outputs on the next falling edge. This means every check lands exactly one register stage after its stimulus.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int TMR_W   = 21;
  localparam int TMR_LSB = 9;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h01;
  localparam logic [ADDR_W-1:0] A_ADV     = 5'h04;
  localparam logic [ADDR_W-1:0] A_PART    = 5'h05;
  localparam logic [ADDR_W-1:0] A_EXP     = 5'h06;
  localparam logic [ADDR_W-1:0] A_NP_DEV  = 5'h07;
  localparam logic [ADDR_W-1:0] A_NP_PART = 5'h08;
  localparam logic [ADDR_W-1:0] A_SCR     = 5'h10;
  localparam logic [ADDR_W-1:0] A_TMR_LO  = 5'h12;
  localparam logic [ADDR_W-1:0] A_TMR_HI  = 5'h13;
  localparam logic [ADDR_W-1:0] A_IFM     = 5'h14;

  localparam int B_SRST = 15;
  localparam int B_ANEN = 12;
  localparam int B_RSTA = 9;

  localparam logic [DATA_W-1:0] ADV_MASK  = 16'h31A0;
  localparam logic [DATA_W-1:0] ADV_RESET = 16'h01A0;

  localparam int REQ_N   = 2;
  localparam int REQ_RST = 0;
  localparam int REQ_AN  = 1;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;
endpackage

// File: rtl/pcs_req_bit.sv
module pcs_req_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R3 and R4: a pending request waits for its acknowledge
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && !clr_i |=> q_q);
  p_req_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && clr_i && !set_i |=> !q_q);
  p_req_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
endmodule

// File: rtl/pcs_stat_track.sv
module pcs_stat_track (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up_i,
  input  logic rd_stat_i,
  input  logic page_i,
  input  logic rd_exp_i,
  output logic link_o,
  output logic page_o
);
  logic link_d, link_q;
  logic page_d, page_q;

  always_comb begin
    link_d = link_q;
    if (rd_stat_i)       link_d = link_up_i;
    else if (!link_up_i) link_d = 1'b0;
    page_d = page_q;
    if (rd_exp_i) page_d = 1'b0;
    if (page_i)   page_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      page_q <= 1'b0;
    end else begin
      link_q <= link_d;
      page_q <= page_d;
    end
  end

  assign link_o = link_q;
  assign page_o = page_q;

  p_link_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_i |=> !link_q);
  p_link_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat_i && !link_q |=> !link_q);
  p_page_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_i |=> page_q);
  p_page_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_exp_i && !page_i |=> !page_q);
endmodule

// File: rtl/pcs_link_timer.sv
module pcs_link_timer #(
  parameter int DW      = 16,
  parameter int TW      = 21,
  parameter int LSB     = 9,
  parameter logic [20:0] RST_VAL = 21'h98A00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [TW-1:0] timer_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  localparam int KW      = TW - LSB;
  localparam int LO_KEEP = DW - LSB;
  localparam int HI_KEEP = TW - DW;

  logic [KW-1:0] kept_d, kept_q;

  always_comb begin
    kept_d = kept_q;
    if (wr_lo_i) kept_d[LO_KEEP-1:0]  = wdata_i[DW-1:LSB];
    if (wr_hi_i) kept_d[KW-1:LO_KEEP] = wdata_i[HI_KEEP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kept_q <= RST_VAL[TW-1:LSB];
    else        kept_q <= kept_d;
  end

  assign timer_o = {kept_q, {LSB{1'b0}}};
  assign lo_o    = timer_o[DW-1:0];
  assign hi_o    = {{(2*DW-TW){1'b0}}, timer_o[TW-1:DW]};

  p_tmr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo_i && !wr_hi_i |=> $stable(timer_o));
endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
  import pcs_mgmt_pkg::*;
#(
  parameter logic [TMR_W-1:0] TMR_RESET = 21'h98A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rst_done,
  input  logic              an_restart_ack,
  input  logic              link_up,
  input  logic              an_complete,
  input  logic              page_rx,
  input  logic              partner_an_able,
  input  logic [DATA_W-1:0] partner_ability,
  output logic              soft_rst_req,
  output logic              an_restart_req,
  output logic              an_enable,
  output logic [DATA_W-1:0] adv_ability,
  output logic [TMR_W-1:0]  link_timer,
  output logic              sgmii_en,
  output logic              use_an_speed,
  output logic [1:0]        speed_sel
);
  logic wr_ctrl, wr_adv, wr_scr, wr_tlo, wr_thi, wr_ifm;
  logic rd_stat, rd_exp, mapped;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_adv  = wr_en && (addr == A_ADV);
  assign wr_scr  = wr_en && (addr == A_SCR);
  assign wr_tlo  = wr_en && (addr == A_TMR_LO);
  assign wr_thi  = wr_en && (addr == A_TMR_HI);
  assign wr_ifm  = wr_en && (addr == A_IFM);
  assign rd_stat = rd_en && (addr == A_STAT);
  assign rd_exp  = rd_en && (addr == A_EXP);

  always_comb begin
    unique case (addr)
      A_CTRL, A_STAT, A_ADV, A_PART, A_EXP, A_NP_DEV, A_NP_PART,
      A_SCR, A_TMR_LO, A_TMR_HI, A_IFM: mapped = 1'b1;
      default:                          mapped = 1'b0;
    endcase
  end

  // Request bits that the core acknowledges
  logic [REQ_N-1:0] req_set, req_clr, req_q;
  assign req_set[REQ_RST] = wr_ctrl && wdata[B_SRST];
  assign req_clr[REQ_RST] = rst_done;
  assign req_set[REQ_AN]  = wr_ctrl && wdata[B_RSTA];
  assign req_clr[REQ_AN]  = an_restart_ack;

  for (genvar i = 0; i < REQ_N; i++) begin : g_req
    pcs_req_bit u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (req_set[i]),
      .clr_i (req_clr[i]),
      .q_o   (req_q[i])
    );
  end

  logic link_lat, page_flag;
  pcs_stat_track u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up_i (link_up),
    .rd_stat_i (rd_stat),
    .page_i    (page_rx),
    .rd_exp_i  (rd_exp),
    .link_o    (link_lat),
    .page_o    (page_flag)
  );

  logic [DATA_W-1:0] tmr_lo, tmr_hi;
  pcs_link_timer #(
    .DW      (DATA_W),
    .TW      (TMR_W),
    .LSB     (TMR_LSB),
    .RST_VAL (TMR_RESET)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo_i (wr_tlo),
    .wr_hi_i (wr_thi),
    .wdata_i (wdata),
    .timer_o (link_timer),
    .lo_o    (tmr_lo),
    .hi_o    (tmr_hi)
  );

  // Plain read-write storage
  logic              anen_d, anen_q;
  logic [DATA_W-1:0] adv_d, adv_q;
  logic [DATA_W-1:0] scr_d, scr_q;
  logic [3:0]        ifm_d, ifm_q;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic [DATA_W-1:0] rmux;

  always_comb begin
    anen_d = anen_q;
    adv_d  = adv_q;
    scr_d  = scr_q;
    ifm_d  = ifm_q;
    if (wr_ctrl) anen_d = wdata[B_ANEN];
    if (wr_adv)  adv_d  = wdata & ADV_MASK;
    if (wr_scr)  scr_d  = wdata;
    if (wr_ifm)  ifm_d  = wdata[3:0];
  end

  always_comb begin
    rmux = '0;
    unique case (addr)
      A_CTRL: begin
        rmux[B_SRST] = req_q[REQ_RST];
        rmux[B_ANEN] = anen_q;
        rmux[B_RSTA] = req_q[REQ_AN];
      end
      A_STAT: begin
        rmux[5] = an_complete;
        rmux[3] = 1'b1;
        rmux[2] = link_lat;
      end
      A_ADV:    rmux = adv_q;
      A_PART:   rmux = partner_ability;
      A_EXP: begin
        rmux[1] = page_flag;
        rmux[0] = partner_an_able;
      end
      A_SCR:    rmux = scr_q;
      A_TMR_LO: rmux = tmr_lo;
      A_TMR_HI: rmux = tmr_hi;
      A_IFM:    rmux[3:0] = ifm_q;
      default:  rmux = '0;
    endcase
    rd_d = rd_en ? rmux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anen_q <= 1'b0;
      adv_q  <= ADV_RESET;
      scr_q  <= '0;
      ifm_q  <= '0;
      rd_q   <= '0;
    end else begin
      anen_q <= anen_d;
      adv_q  <= adv_d;
      scr_q  <= scr_d;
      ifm_q  <= ifm_d;
      rd_q   <= rd_d;
    end
  end

  // Effective speed for the core
  speed_e spd;
  always_comb begin
    if (!ifm_q[0])     spd = SPD_1G;
    else if (ifm_q[1]) spd = speed_e'(partner_ability[11:10]);
    else               spd = speed_e'(ifm_q[3:2]);
  end

  assign rdata          = rd_q;
  assign soft_rst_req   = req_q[REQ_RST];
  assign an_restart_req = req_q[REQ_AN];
  assign an_enable      = anen_q;
  assign adv_ability    = adv_q;
  assign sgmii_en       = ifm_q[0];
  assign use_an_speed   = ifm_q[1];
  assign speed_sel      = spd;

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  p_stat_able_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == A_STAT) |=> rdata[3]);
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !mapped |=> rdata == '0);
  p_adv_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ability & ~ADV_MASK) == '0);
  p_x_mode_1g_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sgmii_en |-> speed_sel == 2'b10);
endmodule

// File: tb/pcs_mgmt_regs_tb.sv
module pcs_mgmt_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata, rdata;
  logic        rst_done, an_restart_ack, link_up, an_complete, page_rx, partner_an_able;
  logic [15:0] partner_ability, adv_ability;
  logic        soft_rst_req, an_restart_req, an_enable, sgmii_en, use_an_speed;
  logic [20:0] link_timer;
  logic [1:0]  speed_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pcs_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_done(rst_done),
    .an_restart_ack(an_restart_ack), .link_up(link_up),
    .an_complete(an_complete), .page_rx(page_rx),
    .partner_an_able(partner_an_able), .partner_ability(partner_ability),
    .soft_rst_req(soft_rst_req), .an_restart_req(an_restart_req),
    .an_enable(an_enable), .adv_ability(adv_ability), .link_timer(link_timer),
    .sgmii_en(sgmii_en), .use_an_speed(use_an_speed), .speed_sel(speed_sel)
  );

  // Model state
  logic        m_rst, m_ran, m_anen, m_link, m_page;
  logic [15:0] m_adv, m_scr;
  logic [11:0] m_tmr;
  logic [3:0]  m_ifm;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(logic [4:0] a);
    case (a)
      5'h00: return "R3 R4";
      5'h01: return "R5";
      5'h04: return "R8";
      5'h06: return "R6";
      5'h05, 5'h07, 5'h08, 5'h10: return "R10";
      5'h12, 5'h13: return "R7";
      5'h14: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] exp_read(logic [4:0] a);
    logic [15:0] v = '0;
    case (a)
      5'h00: begin v[15] = m_rst; v[12] = m_anen; v[9] = m_ran; end
      5'h01: begin v[5] = an_complete; v[3] = 1'b1; v[2] = m_link; end
      5'h04: v = m_adv;
      5'h05: v = partner_ability;
      5'h06: begin v[1] = m_page; v[0] = partner_an_able; end
      5'h10: v = m_scr;
      5'h12: v = {m_tmr[6:0], 9'b0};
      5'h13: v = {11'b0, m_tmr[11:7]};
      5'h14: v = {12'b0, m_ifm};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [1:0] exp_spd();
    if (!m_ifm[0]) return 2'b10;
    if (m_ifm[1])  return partner_ability[11:10];
    return m_ifm[3:2];
  endfunction

  task automatic model_reset();
    m_rst = 0; m_ran = 0; m_anen = 0; m_link = 0; m_page = 0;
    m_adv = 16'h01A0; m_scr = 0; m_tmr = 12'h4C5; m_ifm = 0;
  endtask

  task automatic check_outputs();
    chk("R3", {31'b0, soft_rst_req}, {31'b0, m_rst});
    chk("R4", {31'b0, an_restart_req}, {31'b0, m_ran});
    chk("R4", {31'b0, an_enable}, {31'b0, m_anen});
    chk("R8", {16'b0, adv_ability}, {16'b0, m_adv});
    chk("R7", {11'b0, link_timer}, {11'b0, m_tmr, 9'b0});
    chk("R9", {30'b0, sgmii_en, use_an_speed}, {30'b0, m_ifm[0], m_ifm[1]});
    chk("R9", {30'b0, speed_sel}, {30'b0, exp_spd()});
  endtask

  // One clock: inputs are already stable; returns at the falling edge
  task automatic step();
    logic        pend = rd_en;
    logic [4:0]  pa = addr;
    logic [15:0] e = rd_en ? exp_read(addr) : 16'h0;
    logic n_rst = m_rst, n_ran = m_ran, n_anen = m_anen, n_link = m_link, n_page = m_page;
    logic [15:0] n_adv = m_adv, n_scr = m_scr;
    logic [11:0] n_tmr = m_tmr;
    logic [3:0]  n_ifm = m_ifm;
    if (rst_done) n_rst = 0;
    if (an_restart_ack) n_ran = 0;
    if (wr_en) begin
      case (addr)
        5'h00: begin
          if (wdata[15]) n_rst = 1;
          if (wdata[9])  n_ran = 1;
          n_anen = wdata[12];
        end
        5'h04: n_adv = wdata & 16'h31A0;
        5'h10: n_scr = wdata;
        5'h12: n_tmr[6:0] = wdata[15:9];
        5'h13: n_tmr[11:7] = wdata[4:0];
        5'h14: n_ifm = wdata[3:0];
        default: ;
      endcase
    end
    if (rd_en && addr == 5'h01) n_link = link_up;
    else if (!link_up)          n_link = 0;
    if (rd_en && addr == 5'h06) n_page = 0;
    if (page_rx)                n_page = 1;
    @(posedge clk);
    m_rst = n_rst; m_ran = n_ran; m_anen = n_anen; m_link = n_link; m_page = n_page;
    m_adv = n_adv; m_scr = n_scr; m_tmr = n_tmr; m_ifm = n_ifm;
    @(negedge clk);
    if (pend) chk(tag(pa), {16'b0, rdata}, {16'b0, e});
    check_outputs();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; rst_done = 0; an_restart_ack = 0; page_rx = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    idle(); wr_en = 1; addr = a; wdata = d; step(); idle();
  endtask

  task automatic rd(logic [4:0] a);
    idle(); rd_en = 1; addr = a; step(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] alist [16] = '{5'h00, 5'h01, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h10,
                               5'h12, 5'h13, 5'h14, 5'h09, 5'h15, 5'h1F, 5'h02, 5'h03};
    void'($urandom(32'd20240708));
    rst_n = 0; idle(); addr = 0; wdata = 0; link_up = 1; an_complete = 0;
    partner_an_able = 0; partner_ability = 16'h0000;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the outputs and through reads
    check_outputs();
    chk("R1", {16'b0, rdata}, 32'h0);
    foreach (alist[i]) rd(alist[i]);
    rd(5'h12); chk("R1", {16'b0, rdata}, 32'h8A00);
    rd(5'h13); chk("R1", {16'b0, rdata}, 32'h0009);
    rd(5'h04); chk("R1", {16'b0, rdata}, 32'h01A0);

    // R2: read returns old value when written in same cycle; data holds
    wr(5'h10, 16'hA5A5);
    idle(); wr_en = 1; rd_en = 1; addr = 5'h10; wdata = 16'h1234; step(); idle();
    chk("R2", {16'b0, rdata}, 32'hA5A5);
    step(); step();
    chk("R2", {16'b0, rdata}, 32'hA5A5);
    rd(5'h10); chk("R10", {16'b0, rdata}, 32'h1234);

    // R3: soft reset waits for rst_done; write 0 does not clear; scratch kept
    wr(5'h00, 16'h8000);
    repeat (4) step();
    wr(5'h00, 16'h0000);
    chk("R3", {31'b0, soft_rst_req}, 32'h1);
    rst_done = 1; step(); rst_done = 0;
    chk("R3", {31'b0, soft_rst_req}, 32'h0);
    idle(); wr_en = 1; addr = 5'h00; wdata = 16'h8000; rst_done = 1; step(); idle();
    chk("R3", {31'b0, soft_rst_req}, 32'h1);
    rst_done = 1; step(); rst_done = 0;
    rd(5'h10); chk("R3", {16'b0, rdata}, 32'h1234);

    // R4: restart request and enable bit
    wr(5'h00, 16'h1200);
    rd(5'h00); chk("R4", {16'b0, rdata}, 32'h1200);
    an_restart_ack = 1; step(); an_restart_ack = 0;
    rd(5'h00); chk("R4", {16'b0, rdata}, 32'h1000);

    // R5: link latches low across a recovery
    rd(5'h01);
    rd(5'h01); chk("R5", {16'b0, rdata}, 32'h000C);
    link_up = 0; step(); link_up = 1; step(); step();
    rd(5'h01); chk("R5", {16'b0, rdata}, 32'h0008);
    an_complete = 1;
    rd(5'h01); chk("R5", {16'b0, rdata}, 32'h002C);

    // R6: page flag set, read, cleared; coincident set wins
    page_rx = 1; step(); page_rx = 0;
    rd(5'h06); chk("R6", {16'b0, rdata}, 32'h0002);
    rd(5'h06); chk("R6", {16'b0, rdata}, 32'h0000);
    idle(); rd_en = 1; addr = 5'h06; page_rx = 1; step(); idle();
    rd(5'h06); chk("R6", {16'b0, rdata}, 32'h0002);

    // R7: low timer bits forced to zero
    wr(5'h12, 16'hFFFF); wr(5'h13, 16'hFFFF);
    rd(5'h12); chk("R7", {16'b0, rdata}, 32'hFE00);
    rd(5'h13); chk("R7", {16'b0, rdata}, 32'h001F);
    chk("R7", {11'b0, link_timer}, 32'h1FFE00);

    // R8: only masked bits of advertised ability are writable
    wr(5'h04, 16'hFFFF);
    rd(5'h04); chk("R8", {16'b0, rdata}, 32'h31A0);

    // R9: speed selection in each mode
    partner_ability = 16'h0400;
    wr(5'h14, 16'h0005); chk("R9", {30'b0, speed_sel}, 32'h1);
    wr(5'h14, 16'h0007); chk("R9", {30'b0, speed_sel}, 32'h1);
    partner_ability = 16'h0000; step();
    chk("R9", {30'b0, speed_sel}, 32'h0);
    wr(5'h14, 16'h000C); chk("R9", {30'b0, speed_sel}, 32'h2);

    // R11: unmapped write has no effect anywhere
    wr(5'h09, 16'hFFFF); wr(5'h11, 16'hFFFF);
    rd(5'h09); chk("R11", {16'b0, rdata}, 32'h0);
    rd(5'h10); chk("R11", {16'b0, rdata}, 32'h1234);
    rd(5'h07); chk("R10", {16'b0, rdata}, 32'h0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      wr_en           = ($urandom_range(0, 9) < 3);
      rd_en           = ($urandom_range(0, 9) < 4);
      addr            = alist[$urandom_range(0, 15)];
      wdata           = 16'($urandom);
      rst_done        = ($urandom_range(0, 4) == 0);
      an_restart_ack  = ($urandom_range(0, 4) == 0);
      link_up         = ($urandom_range(0, 9) != 0);
      an_complete     = 1'($urandom);
      page_rx         = ($urandom_range(0, 9) == 0);
      partner_an_able = 1'($urandom);
      if ($urandom_range(0, 7) == 0) partner_ability = 16'($urandom);
      step();
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule